// File: doc/BRIEF.md
# Byte-Mask CRC Flow Tag Generator

This block derives a 32-bit flow tag for each incoming packet. Software picks which bytes of the packet take part in the hash. It does this by writing one of four byte-offset bitmaps. Each bitmap covers the first 128 bytes of the packet data. The packet arrives one byte per beat, with start and end strobes. The start beat also carries a bitmap select and an interface index.

Every byte whose enable bit is set in the chosen bitmap is folded into a CRC-32. The CRC runs one byte per beat. Its starting value, its bit reflection and its final inversion come from a settings pair that is held separately for each of two interfaces. One cycle after the end beat, the finished tag appears on the output together with a single-cycle valid pulse.

Typical use: software clears a bitmap, then sets the bits for the header fields that identify a flow (addresses, ports). Packets are then steered to that bitmap through the select input.

Top module: `tagcrc_gen`

## Requirements
- R1: After reset the tag output is 0 and tag_valid is low. All four bitmaps are all-zero. Each interface has IV 0xFFFFFFFF with reflect and invert off.
- R2: A write to an address in 0x00..0x3F loads wdata[7:0] into one bitmap entry. The bitmap number is addr[5:4] and the entry number is addr[3:0]. Inside an entry, byte offset X of the packet uses entry X/8 and bit (7 - X mod 8), so bit 7 is the lowest offset.
- R3: Only bytes at offsets 0..127 whose enable bit is set enter the CRC. Bytes at offset 128 and beyond never affect the tag.
- R4: With reflect off, each selected byte is shifted MSB first into a CRC-32 with polynomial 0x04C11DB7, starting from the interface IV.
- R5: With reflect on, each selected byte is bit-reversed before it enters the CRC, and the 32-bit result is bit-reversed at the end.
- R6: With invert on, the final tag is the bitwise complement of the CRC result.
- R7: Writing 0x40 + 2*i loads the 32-bit IV of interface i. Writing 0x41 + 2*i loads its controls: bit 0 is reflect and bit 1 is invert. The interface index is sampled on the start beat, and a packet uses that interface's settings.
- R8: The bitmap select is sampled on the start beat. The four bitmaps are independent of each other.
- R9: Any write to 0x48 + m clears all 16 entries of bitmap m. The other bitmaps are left unchanged.
- R10: tag_valid pulses high for exactly one cycle, in the cycle after the end beat. The tag holds its value until the next end beat.
- R11: When a packet has no selected byte, the tag is the IV, complemented if invert is on and never bit-reversed.
- R12: Cycles with in_valid low are ignored. They do not advance the byte offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register write address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Byte beat valid |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| in_data | input | 8 | Packet byte |
| in_mask_sel | input | 2 | Bitmap select, sampled on the start beat |
| in_ifc | input | 1 | Interface index, sampled on the start beat |
| tag_valid | output | 1 | One-cycle pulse, tag is ready |
| tag | output | 32 | Flow tag |

## Verification
The bench targets the MSB-first bit order inside a bitmap entry: a design that reverses it hashes the wrong bytes, and the tags differ. It uses the standard reflected check string, whose known tag only appears if both the input and the output reversal are right. It sends packets longer than 128 bytes: a design whose offset counter wraps would fold the tail bytes back into the hash. It also sends packets with no selected bytes, where a design that reverses or skips the IV gives a wrong tag, and it changes the select and interface inputs after the start beat, which must have no effect. It clears one bitmap while another stays live, to catch a clear that reaches too far.

// File: rtl/tagcrc_pkg.sv
// Shared types and CRC helpers for the flow tag generator.
// Assumes a byte-serial CRC-32 in the non-reflected (MSB first) domain.
package tagcrc_pkg;

    localparam int          CRC_W = 32;
    localparam logic [31:0] POLY  = 32'h04C1_1DB7;

    // Per-interface CRC settings
    typedef struct packed {
        logic [CRC_W-1:0] iv;
        logic             reflect;
        logic             invert;
    } crc_cfg_t;

    // Advance the CRC by one byte, MSB first
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                 input logic [7:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            if (r[CRC_W-1] ^ d[b]) r = {r[CRC_W-2:0], 1'b0} ^ POLY;
            else                   r = {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction

    // Bit-reverse a byte
    function automatic logic [7:0] rev8(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = d[7-i];
        return r;
    endfunction

    // Bit-reverse a CRC word
    function automatic logic [CRC_W-1:0] rev_crc(input logic [CRC_W-1:0] d);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = d[CRC_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/tagcrc_mask_store.sv
// Byte-offset bitmap storage: NUM_MASKS bitmaps of ENTRIES 8-bit entries.
// Provides one write port, one whole-bitmap clear and one combinational
// read port. Assumes a clear and a write never target the same bitmap in
// the same cycle (the address decode makes them exclusive).
module tagcrc_mask_store #(
    parameter int NUM_MASKS = 4,
    parameter int ENTRIES   = 16,
    localparam int MASK_W   = $clog2(NUM_MASKS),
    localparam int ENT_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic [7:0]        wr_data,
    input  logic              clr_en,
    input  logic [MASK_W-1:0] clr_mask,
    input  logic [MASK_W-1:0] rd_mask,
    input  logic [ENT_W-1:0]  rd_entry,
    output logic [7:0]        rd_bits
);

    logic [ENTRIES-1:0][7:0] row [NUM_MASKS];

    for (genvar m = 0; m < NUM_MASKS; m++) begin : g_row
        // Hold one bitmap: reset, clear or single-entry write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row[m] <= '0;
            end else if (clr_en && clr_mask == MASK_W'(m)) begin
                row[m] <= '0;
            end else if (wr_en && wr_mask == MASK_W'(m)) begin
                row[m][wr_entry] <= wr_data;
            end
        end

        // R9
        clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_mask == MASK_W'(m)) |=> (row[m] == '0));

        // R2
        entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !clr_en && wr_mask == MASK_W'(m))
                |=> (row[m][$past(wr_entry)] == $past(wr_data)));
    end

    // Look up the addressed entry
    always_comb rd_bits = row[rd_mask][rd_entry];

endmodule

// File: rtl/tagcrc_cfg_regs.sv
// Per-interface CRC settings: IV, reflect and invert for NUM_IFC interfaces.
// IV and controls are written separately; the read side is combinational.
module tagcrc_cfg_regs
    import tagcrc_pkg::*;
#(
    parameter int               NUM_IFC = 2,
    parameter logic [CRC_W-1:0] IV_RST  = 32'hFFFF_FFFF,
    localparam int              IFC_W   = (NUM_IFC > 1) ? $clog2(NUM_IFC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_iv_en,
    input  logic             wr_ctl_en,
    input  logic [IFC_W-1:0] wr_ifc,
    input  logic [CRC_W-1:0] wr_data,
    input  logic [IFC_W-1:0] rd_ifc,
    output crc_cfg_t         rd_cfg
);

    crc_cfg_t cfg_q [NUM_IFC];

    for (genvar i = 0; i < NUM_IFC; i++) begin : g_ifc
        // Hold one interface's settings
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= '{iv: IV_RST, reflect: 1'b0, invert: 1'b0};
            end else if (wr_iv_en && wr_ifc == IFC_W'(i)) begin
                cfg_q[i].iv <= wr_data;
            end else if (wr_ctl_en && wr_ifc == IFC_W'(i)) begin
                cfg_q[i].reflect <= wr_data[0];
                cfg_q[i].invert  <= wr_data[1];
            end
        end

        // R7
        iv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_iv_en && wr_ifc == IFC_W'(i)) |=> (cfg_q[i].iv == $past(wr_data)));

        // R7
        ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ctl_en && !wr_iv_en && wr_ifc == IFC_W'(i))
                |=> ({cfg_q[i].invert, cfg_q[i].reflect} == $past(wr_data[1:0])));
    end

    // Select the settings of the requested interface
    always_comb rd_cfg = cfg_q[rd_ifc];

endmodule

// File: rtl/tagcrc_engine.sv
// Byte-serial CRC accumulator with offset tracking.
// Each valid beat carries one byte and its enable bit (looked up by the
// caller from beat_idx). Bytes at offset WINDOW or later are discarded.
// The tag is registered on the end beat. Assumes cfg is stable for a packet.
module tagcrc_engine
    import tagcrc_pkg::*;
#(
    parameter int  WINDOW = 128,
    localparam int OFF_W  = $clog2(WINDOW) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_sop,
    input  logic             beat_eop,
    input  logic [7:0]       beat_data,
    input  logic             beat_sel,
    input  crc_cfg_t         cfg,
    output logic [OFF_W-2:0] beat_idx,
    output logic             tag_valid,
    output logic [CRC_W-1:0] tag
);

    localparam logic [OFF_W-1:0] WIN_L = OFF_W'(WINDOW);

    logic [OFF_W-1:0] off_q, cur_off;
    logic             in_win, take;
    logic [CRC_W-1:0] crc_q, crc_base, crc_nx, result;
    logic             any_q, any_nx;
    logic [7:0]       din;

    // Offset of the current beat; the start beat is offset 0
    always_comb begin
        cur_off  = beat_sop ? '0 : off_q;
        in_win   = cur_off < WIN_L;
        beat_idx = cur_off[OFF_W-2:0];
        take     = beat_valid && beat_sel && in_win;
    end

    // Next CRC state and final tag value
    always_comb begin
        crc_base = beat_sop ? cfg.iv : crc_q;
        din      = cfg.reflect ? rev8(beat_data) : beat_data;
        crc_nx   = take ? crc_byte(crc_base, din) : crc_base;
        any_nx   = (beat_sop ? 1'b0 : any_q) | take;
        result   = (cfg.reflect && any_nx) ? rev_crc(crc_nx) : crc_nx;
        if (cfg.invert) result = ~result;
    end

    // Offset counter, saturating at the window edge
    always_ff @(posedge clk) begin
        if (!rst_n)                    off_q <= '0;
        else if (beat_valid && in_win) off_q <= cur_off + 1'b1;
        else if (beat_valid)           off_q <= cur_off;
    end

    // CRC and any-byte state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
            any_q <= 1'b0;
        end else if (beat_valid) begin
            crc_q <= crc_nx;
            any_q <= any_nx;
        end
    end

    // Tag register and one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_valid <= 1'b0;
            tag       <= '0;
        end else begin
            tag_valid <= beat_valid && beat_eop;
            if (beat_valid && beat_eop) tag <= result;
        end
    end

    // R3
    off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= WIN_L);

    // R10
    valid_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> $past(beat_valid && beat_eop));

    // R10
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_valid |-> $stable(tag));

    // R12
    bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> ($stable(off_q) && $stable(crc_q)));

endmodule

// File: rtl/tagcrc_gen.sv
// Flow tag generator top: register decode, bitmap store, per-interface CRC
// settings and the byte-serial engine. The bitmap select and interface index
// are sampled on the start beat and held for the rest of the packet.
// Register map: 0x00-0x3F bitmap entries, 0x40+2i IV, 0x41+2i controls,
// 0x48+m clear bitmap m.
module tagcrc_gen
    import tagcrc_pkg::*;
#(
    parameter int               NUM_MASKS = 4,
    parameter int               ENTRIES   = 16,
    parameter int               NUM_IFC   = 2,
    parameter logic [CRC_W-1:0] IV_RST    = 32'hFFFF_FFFF,
    localparam int              WINDOW    = ENTRIES * 8,
    localparam int              MASK_W    = $clog2(NUM_MASKS),
    localparam int              ENT_W     = $clog2(ENTRIES),
    localparam int              IFC_W     = (NUM_IFC > 1) ? $clog2(NUM_IFC) : 1,
    localparam int              OFF_W     = $clog2(WINDOW) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_data,
    input  logic [MASK_W-1:0] in_mask_sel,
    input  logic [IFC_W-1:0]  in_ifc,
    output logic              tag_valid,
    output logic [CRC_W-1:0]  tag
);

    logic              wr_mask_en, wr_iv_en, wr_ctl_en, clr_en, cfg_hit;
    logic [MASK_W-1:0] mask_q, cur_mask;
    logic [IFC_W-1:0]  ifc_q, cur_ifc;
    logic [OFF_W-2:0]  beat_idx;
    logic [7:0]        rd_bits;
    logic              beat_sel;
    crc_cfg_t          cur_cfg;

    // Decode the register write address
    always_comb begin
        cfg_hit    = reg_addr[6:3] == 4'b1000 && reg_addr[2:1] < 2'(NUM_IFC);
        wr_mask_en = reg_we && !reg_addr[6];
        wr_iv_en   = reg_we && cfg_hit && !reg_addr[0];
        wr_ctl_en  = reg_we && cfg_hit &&  reg_addr[0];
        clr_en     = reg_we && reg_addr[6:3] == 4'b1001 && reg_addr[2] == 1'b0;
    end

    // Capture the packet's bitmap select and interface on the start beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ifc_q  <= '0;
        end else if (in_valid && in_sop) begin
            mask_q <= in_mask_sel;
            ifc_q  <= in_ifc;
        end
    end

    // Live values for the start beat, held values afterwards
    always_comb begin
        cur_mask = (in_valid && in_sop) ? in_mask_sel : mask_q;
        cur_ifc  = (in_valid && in_sop) ? in_ifc      : ifc_q;
        beat_sel = rd_bits[3'd7 - beat_idx[2:0]];
    end

    tagcrc_mask_store #(
        .NUM_MASKS (NUM_MASKS),
        .ENTRIES   (ENTRIES)
    ) u_masks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_mask_en),
        .wr_mask  (reg_addr[ENT_W +: MASK_W]),
        .wr_entry (reg_addr[ENT_W-1:0]),
        .wr_data  (reg_wdata[7:0]),
        .clr_en   (clr_en),
        .clr_mask (reg_addr[MASK_W-1:0]),
        .rd_mask  (cur_mask),
        .rd_entry (beat_idx[OFF_W-2:3]),
        .rd_bits  (rd_bits)
    );

    tagcrc_cfg_regs #(
        .NUM_IFC (NUM_IFC),
        .IV_RST  (IV_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_iv_en  (wr_iv_en),
        .wr_ctl_en (wr_ctl_en),
        .wr_ifc    (reg_addr[1 +: IFC_W]),
        .wr_data   (reg_wdata),
        .rd_ifc    (cur_ifc),
        .rd_cfg    (cur_cfg)
    );

    tagcrc_engine #(
        .WINDOW (WINDOW)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (in_valid),
        .beat_sop   (in_sop),
        .beat_eop   (in_eop),
        .beat_data  (in_data),
        .beat_sel   (beat_sel),
        .cfg        (cur_cfg),
        .beat_idx   (beat_idx),
        .tag_valid  (tag_valid),
        .tag        (tag)
    );

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop) |=> $stable(mask_q) && $stable(ifc_q));

endmodule

// File: tb/tagcrc_gen_test.sv
// Self-checking bench: directed corner cases plus seeded random packets,
// compared against a reference CRC written in LSB/MSB-first forms.
module tagcrc_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = '0;
    logic [1:0]  in_mask_sel = '0;
    logic [0:0]  in_ifc = '0;
    logic        tag_valid;
    logic [31:0] tag;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_mask [4][16];
    logic [31:0] m_iv   [2];
    bit          m_ref  [2];
    bit          m_inv  [2];
    logic [7:0]  pkt    [200];

    always #2 clk = ~clk;

    tagcrc_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_mask_sel(in_mask_sel),
        .in_ifc(in_ifc), .tag_valid(tag_valid), .tag(tag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] brev(input logic [31:0] d);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = d[31-i];
        return r;
    endfunction

    // Reference tag: MSB-first shift when not reflected, LSB-first with the
    // reflected polynomial when reflected.
    function automatic logic [31:0] ref_tag(input int len, input int ms, input int fi);
        logic [31:0] c;
        bit any = 0;
        c = m_ref[fi] ? brev(m_iv[fi]) : m_iv[fi];
        for (int i = 0; i < len && i < 128; i++) begin
            if (m_mask[ms][i/8][7 - (i%8)]) begin
                any = 1;
                for (int b = 0; b < 8; b++) begin
                    if (m_ref[fi]) begin
                        if (c[0] ^ pkt[i][b]) c = (c >> 1) ^ 32'hEDB8_8320;
                        else                  c = c >> 1;
                    end else begin
                        if (c[31] ^ pkt[i][7-b]) c = (c << 1) ^ 32'h04C1_1DB7;
                        else                     c = c << 1;
                    end
                end
            end
        end
        if (!any) c = m_iv[fi];
        return m_inv[fi] ? ~c : c;
    endfunction

    task automatic reg_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a < 7'h40) m_mask[a[5:4]][a[3:0]] = d[7:0];
        else if (a >= 7'h40 && a <= 7'h43) begin
            if (!a[0]) m_iv[a[1]] = d;
            else begin m_ref[a[1]] = d[0]; m_inv[a[1]] = d[1]; end
        end else if (a >= 7'h48 && a <= 7'h4B)
            for (int e = 0; e < 16; e++) m_mask[a[1:0]][e] = 8'h00;
    endtask

    task automatic send_pkt(input int len, input int ms, input int fi,
                            input bit bub, input string req);
        logic [31:0] exp;
        exp = ref_tag(len, ms, fi);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (bub && ($urandom % 4) == 0) begin
                in_valid = 1'b0; in_data = 8'($urandom);
                in_sop = 1'b1; in_eop = 1'b1;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sop = (i == 0);
            in_eop = (i == len - 1);
            in_data = pkt[i];
            if (i == 0) begin
                in_mask_sel = 2'(ms); in_ifc = 1'(fi);
            end else begin
                in_mask_sel = 2'($urandom); in_ifc = 1'($urandom);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        chk(tag_valid == 1'b1, {req, " R10 valid"}, {31'd0, tag_valid}, 32'd1);
        chk(tag == exp, req, tag, exp);
        @(negedge clk);
        chk(tag_valid == 1'b0, "R10 pulse", {31'd0, tag_valid}, 32'd0);
        chk(tag == exp, "R10 hold", tag, exp);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 16; e++) m_mask[m][e] = 8'h00;
        for (int f = 0; f < 2; f++) begin
            m_iv[f] = 32'hFFFF_FFFF; m_ref[f] = 0; m_inv[f] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tag_valid == 1'b0, "R1 valid", {31'd0, tag_valid}, 32'd0);
        chk(tag == 32'd0, "R1 tag", tag, 32'd0);

        // R1 / R11: empty bitmaps give the default IV
        for (int i = 0; i < 20; i++) pkt[i] = 8'(i * 7);
        send_pkt(20, 3, 1, 0, "R1 R11 empty");

        // R5 R6 R4: standard check string, offsets 0..8 selected
        for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
        reg_wr(7'h00, 32'hFF);
        reg_wr(7'h01, 32'h80);
        reg_wr(7'h41, 32'h3);
        send_pkt(9, 0, 0, 0, "R5 R6 reflected check");
        chk(tag == 32'hCBF4_3926, "R5 known value", tag, 32'hCBF4_3926);
        reg_wr(7'h41, 32'h2);
        send_pkt(9, 0, 0, 0, "R4 R6 plain check");
        chk(tag == 32'hFC89_1918, "R4 known value", tag, 32'hFC89_1918);

        // R2: single-bit entry picks one offset (bit 7 -> lowest offset)
        reg_wr(7'h00, 32'h00);
        reg_wr(7'h01, 32'h00);
        reg_wr(7'h12, 32'h20);
        for (int i = 0; i < 40; i++) pkt[i] = 8'($urandom);
        send_pkt(40, 1, 0, 0, "R2 entry bit order");

        // R11: reflect and invert with no byte selected, custom IV
        reg_wr(7'h42, 32'h1234_5678);
        reg_wr(7'h43, 32'h3);
        send_pkt(10, 2, 1, 0, "R11 iv reflect invert");

        // R3: bitmap full, long packet; tail bytes must not matter
        for (int e = 0; e < 16; e++) reg_wr(7'h30 + 7'(e), 32'hFF);
        for (int i = 0; i < 200; i++) pkt[i] = 8'($urandom);
        send_pkt(200, 3, 0, 1, "R3 window");

        // R9: clear bitmap 3, bitmap 1 keeps its entry
        reg_wr(7'h4B, 32'h0);
        send_pkt(50, 3, 0, 0, "R9 cleared");
        send_pkt(50, 1, 1, 0, "R9 neighbour kept");

        // R7 R8 R12: random settings, bitmaps, lengths and bubbles
        for (int n = 0; n < 80; n++) begin
            if ($urandom % 3 == 0) reg_wr(7'h40 + 7'($urandom % 4), $urandom);
            for (int k = 0; k < 3; k++) reg_wr(7'($urandom % 64), $urandom);
            if ($urandom % 10 == 0) reg_wr(7'h48 + 7'($urandom % 4), 0);
            for (int i = 0; i < 200; i++) pkt[i] = 8'($urandom);
            send_pkt(1 + int'($urandom % 160), int'($urandom % 4),
                     int'($urandom % 2), 1, "R7 R8 R12 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule